// File: doc/BRIEF.md
# Delegated QoS Identifier Register Filter

This block keeps the two resource-tagging registers of a hart: one used while the hart runs at machine level and one used below it. Each register holds a resource-control identifier (RCID) and a monitoring-counter identifier (MCID). Every outgoing memory request carries these identifiers, plus a controller-interface identifier (QRID), taken from whichever register matches the request's effective privilege.

Machine firmware gives supervisor software a window of identifier values to choose from. It sets a mode bit and two window lengths, and this block filters supervisor reads and writes to match. With the mode bit set, the block keeps a prefix that firmware chose. Supervisor writes can only change the low bits, and supervisor reads show only those low bits. With the mode bit clear, the block rejects any supervisor write that would fall into the topmost aligned block of values, so supervisor code stays below that block. Machine-level accesses are never filtered.

CSR reads are combinational. Writes take effect at the clock edge where the write strobe is sampled.

Top module: `qos_id_filter`

## Requirements
- R1: After reset both registers hold RCID 0 and MCID 0, and a machine-level read of either register returns 0.
- R2: In CSR data, RCID sits in bits 11:0 and MCID in bits 27:16. Every other bit, and any field bit at or above the implemented width (RCID_W, MCID_W), reads as 0 and is ignored on write.
- R3: An access with `csr_priv` = 2'b11 (machine level) reads or writes either register with no filtering.
- R4: Below machine level, writes to the machine register leave it unchanged and reads of it return 0.
- R5: A supervisor-level read of the supervisor register with `prefix_lock`=1 returns each field ANDed with a mask of its window length's low bits. With `prefix_lock`=0 it returns the stored value.
- R6: A supervisor-level write with `prefix_lock`=1 replaces only the low window-length bits of each field. The upper bits keep their value.
- R7: A supervisor-level write with `prefix_lock`=0 stores a field only if (new value OR low-window mask) is not all ones at the field width. Otherwise that field keeps its value. RCID and MCID are judged separately.
- R8: A window length above 12 (`rc_win`, `mc_win`) behaves exactly as 12.
- R9: When `req_priv` = 2'b11, the request outputs carry the machine register's RCID/MCID and `mach_qrid`. Otherwise they carry the supervisor register's fields and `sup_qrid`.
- R10: A cycle without `csr_we`, or without a register select, changes no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_mreg | input | 1 | Access targets the machine register (wins if both selects are high) |
| sel_sreg | input | 1 | Access targets the supervisor register |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | DATA_W | Write data |
| csr_priv | input | 2 | Privilege of the CSR access (2'b11 = machine) |
| prefix_lock | input | 1 | Delegation mode bit |
| rc_win | input | 4 | Supervisor RCID window length |
| mc_win | input | 4 | Supervisor MCID window length |
| sup_qrid | input | QRID_W | QRID for requests below machine level |
| mach_qrid | input | QRID_W | QRID for machine-level requests |
| req_priv | input | 2 | Effective privilege of the outgoing request |
| csr_rdata | output | DATA_W | Read data |
| req_rcid | output | RCID_W | RCID attached to requests |
| req_mcid | output | MCID_W | MCID attached to requests |
| req_qrid | output | QRID_W | QRID attached to requests |

## Verification
The bench targets the boundary of the unlocked range check. With a 5-bit RCID and window 3, value 23 must be stored and 24 dropped; an off-by-one comparison would accept 24 or reject 23. It also checks the locked merge around a firmware prefix of 24. A design that overwrote the whole field would lose the prefix, and one that skipped the read mask would expose it to supervisor reads. Finally, window lengths wider than the field and above 12 are applied along with rejected machine-register accesses below machine level. A design that got these wrong would let supervisor code reach the machine identifiers or fail to clamp the window.

// File: rtl/qos_id_filter.sv
module qos_id_filter #(
  parameter int RCID_W = 12,
  parameter int MCID_W = 12,
  parameter int QRID_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_mreg,
  input  logic              sel_sreg,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic [1:0]        csr_priv,
  input  logic              prefix_lock,
  input  logic [3:0]        rc_win,
  input  logic [3:0]        mc_win,
  input  logic [QRID_W-1:0] sup_qrid,
  input  logic [QRID_W-1:0] mach_qrid,
  input  logic [1:0]        req_priv,
  output logic [DATA_W-1:0] csr_rdata,
  output logic [RCID_W-1:0] req_rcid,
  output logic [MCID_W-1:0] req_mcid,
  output logic [QRID_W-1:0] req_qrid
);
  localparam int MC_LSB  = 16;
  localparam int WIN_MAX = 12;

  function automatic logic [WIN_MAX-1:0] win_mask(input logic [3:0] len);
    logic [3:0] lc;
    lc = (len > 4'(WIN_MAX)) ? 4'(WIN_MAX) : len;
    for (int i = 0; i < WIN_MAX; i++) win_mask[i] = (i < int'(lc));
  endfunction

  function automatic logic [DATA_W-1:0] pack(input logic [RCID_W-1:0] rc,
                                             input logic [MCID_W-1:0] mc);
    pack = '0;
    pack[RCID_W-1:0] = rc;
    pack[MC_LSB +: MCID_W] = mc;
  endfunction

  logic [RCID_W-1:0] m_rc, s_rc, s_rc_nx, wr_rc, rmask;
  logic [MCID_W-1:0] m_mc, s_mc, s_mc_nx, wr_mc, mmask;
  logic [WIN_MAX-1:0] rmask_full, mmask_full;
  logic priv_m, wr_m, wr_s;
  logic unused_wdata;

  assign unused_wdata = ^csr_wdata;
  assign rmask_full = win_mask(rc_win);
  assign mmask_full = win_mask(mc_win);
  assign rmask  = rmask_full[RCID_W-1:0];
  assign mmask  = mmask_full[MCID_W-1:0];
  assign wr_rc  = csr_wdata[RCID_W-1:0];
  assign wr_mc  = csr_wdata[MC_LSB +: MCID_W];
  assign priv_m = (csr_priv == 2'b11);
  assign wr_m   = csr_we && sel_mreg && priv_m;
  assign wr_s   = csr_we && sel_sreg && !sel_mreg;

  always_comb begin
    s_rc_nx = s_rc;
    s_mc_nx = s_mc;
    if (priv_m) begin
      s_rc_nx = wr_rc;
      s_mc_nx = wr_mc;
    end else if (prefix_lock) begin
      s_rc_nx = (s_rc & ~rmask) | (wr_rc & rmask);
      s_mc_nx = (s_mc & ~mmask) | (wr_mc & mmask);
    end else begin
      if (((wr_rc & ~rmask) | rmask) != '1) s_rc_nx = wr_rc;
      if (((wr_mc & ~mmask) | mmask) != '1) s_mc_nx = wr_mc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rc <= '0;
      m_mc <= '0;
      s_rc <= '0;
      s_mc <= '0;
    end else begin
      if (wr_m) begin
        m_rc <= wr_rc;
        m_mc <= wr_mc;
      end
      if (wr_s) begin
        s_rc <= s_rc_nx;
        s_mc <= s_mc_nx;
      end
    end
  end

  logic hide;
  assign hide = !priv_m && prefix_lock;

  always_comb begin
    csr_rdata = '0;
    if (sel_mreg) begin
      if (priv_m) csr_rdata = pack(m_rc, m_mc);
    end else if (sel_sreg) begin
      csr_rdata = hide ? pack(s_rc & rmask, s_mc & mmask) : pack(s_rc, s_mc);
    end
  end

  assign req_rcid = (req_priv == 2'b11) ? m_rc : s_rc;
  assign req_mcid = (req_priv == 2'b11) ? m_mc : s_mc;
  assign req_qrid = (req_priv == 2'b11) ? mach_qrid : sup_qrid;

  // R2: fields outside the identifier positions never read as one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~pack('1, '1)) == '0);

  // R4: lower privilege never touches the machine register
  p_mreg_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && sel_mreg && !priv_m) |=> ($stable(m_rc) && $stable(m_mc)));

  // R5: a hidden read exposes no prefix bit
  p_read_hides_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sreg && !sel_mreg && hide) |->
      ((csr_rdata[RCID_W-1:0] & ~rmask) == '0 &&
       (csr_rdata[MC_LSB +: MCID_W] & ~mmask) == '0));

  // R6: locked supervisor write keeps the prefix
  p_prefix_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && hide) |=>
      ((s_rc & ~$past(rmask)) == ($past(s_rc) & ~$past(rmask)) &&
       (s_mc & ~$past(mmask)) == ($past(s_mc) & ~$past(mmask))));

  // R7: unlocked write into the top block is dropped
  p_top_block_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && !priv_m && !prefix_lock && (((wr_rc & ~rmask) | rmask) == '1))
      |=> $stable(s_rc));

  // R10: no write strobe, no change
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ($stable(m_rc) && $stable(m_mc) && $stable(s_rc) && $stable(s_mc)));
endmodule

// File: tb/qos_id_filter_bench.sv
module qos_id_filter_bench;
  localparam int RW = 5, MW = 7, QW = 4, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_mreg = 0, sel_sreg = 0, csr_we = 0, prefix_lock = 0;
  logic [DW-1:0] csr_wdata = '0;
  logic [1:0] csr_priv = 2'b11, req_priv = 2'b11;
  logic [3:0] rc_win = 0, mc_win = 0;
  logic [QW-1:0] sup_qrid = 4'h5, mach_qrid = 4'hA;
  logic [DW-1:0] csr_rdata;
  logic [RW-1:0] req_rcid;
  logic [MW-1:0] req_mcid;
  logic [QW-1:0] req_qrid;

  qos_id_filter #(.RCID_W(RW), .MCID_W(MW), .QRID_W(QW), .DATA_W(DW)) u_qos_id_filter (
    .clk(clk), .rst_n(rst_n), .sel_mreg(sel_mreg), .sel_sreg(sel_sreg), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_priv(csr_priv), .prefix_lock(prefix_lock),
    .rc_win(rc_win), .mc_win(mc_win), .sup_qrid(sup_qrid), .mach_qrid(mach_qrid),
    .req_priv(req_priv), .csr_rdata(csr_rdata), .req_rcid(req_rcid),
    .req_mcid(req_mcid), .req_qrid(req_qrid));

  always #4 clk = ~clk;

  int errs = 0, checks = 0;
  logic [RW-1:0] m_rc_e = '0, s_rc_e = '0;
  logic [MW-1:0] m_mc_e = '0, s_mc_e = '0;

  function automatic logic [11:0] lowmask(input logic [3:0] len);
    int lc;
    lc = (len > 12) ? 12 : int'(len);
    return 12'((1 << lc) - 1);
  endfunction

  function automatic logic [DW-1:0] packx(input logic [RW-1:0] rc, input logic [MW-1:0] mc);
    logic [DW-1:0] v;
    v = '0;
    v[RW-1:0] = rc;
    v[16 +: MW] = mc;
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_read(input bit selm, input logic [1:0] pr);
    logic [11:0] r12, m12;
    r12 = lowmask(rc_win);
    m12 = lowmask(mc_win);
    if (selm) return (pr == 2'b11) ? packx(m_rc_e, m_mc_e) : '0;
    if (pr != 2'b11 && prefix_lock)
      return packx(s_rc_e & r12[RW-1:0], s_mc_e & m12[MW-1:0]);
    return packx(s_rc_e, s_mc_e);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input bit selm, input logic [1:0] pr, input logic [DW-1:0] d);
    logic [11:0] r12, m12;
    logic [RW-1:0] wr, rm;
    logic [MW-1:0] wm, mm;
    @(negedge clk);
    sel_mreg = selm; sel_sreg = !selm; csr_priv = pr; csr_wdata = d; csr_we = 1'b1;
    r12 = lowmask(rc_win); m12 = lowmask(mc_win);
    rm = r12[RW-1:0]; mm = m12[MW-1:0];
    wr = d[RW-1:0]; wm = d[16 +: MW];
    if (selm) begin
      if (pr == 2'b11) begin m_rc_e = wr; m_mc_e = wm; end
    end else if (pr == 2'b11) begin
      s_rc_e = wr; s_mc_e = wm;
    end else if (prefix_lock) begin
      s_rc_e = (s_rc_e & ~rm) | (wr & rm);
      s_mc_e = (s_mc_e & ~mm) | (wm & mm);
    end else begin
      if (((wr & ~rm) | rm) != '1) s_rc_e = wr;
      if (((wm & ~mm) | mm) != '1) s_mc_e = wm;
    end
    @(negedge clk);
    csr_we = 1'b0; sel_mreg = 1'b0; sel_sreg = 1'b0;
  endtask

  task automatic do_read(input bit selm, input logic [1:0] pr, input string req);
    @(negedge clk);
    sel_mreg = selm; sel_sreg = !selm; csr_priv = pr; csr_we = 1'b0;
    csr_wdata = $urandom;
    #1;
    chk(req, csr_rdata, exp_read(selm, pr));
  endtask

  task automatic check_req(input logic [1:0] ep);
    req_priv = ep;
    #1;
    if (ep == 2'b11) begin
      chk("R9 rcid", DW'(req_rcid), DW'(m_rc_e));
      chk("R9 mcid", DW'(req_mcid), DW'(m_mc_e));
      chk("R9 qrid", DW'(req_qrid), DW'(mach_qrid));
    end else begin
      chk("R9 rcid", DW'(req_rcid), DW'(s_rc_e));
      chk("R9 mcid", DW'(req_mcid), DW'(s_mc_e));
      chk("R9 qrid", DW'(req_qrid), DW'(sup_qrid));
    end
  endtask

  task automatic set_cfg(input logic lk, input logic [3:0] rl, input logic [3:0] ml);
    @(negedge clk);
    prefix_lock = lk; rc_win = rl; mc_win = ml;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_read(1'b1, 2'b11, "R1 mreg");
    do_read(1'b0, 2'b11, "R1 sreg");
    check_req(2'b11);

    // R3 / R2: full machine write, upper and reserved bits dropped
    do_write(1'b0, 2'b11, 32'hFFFF_FFFF);
    do_read(1'b0, 2'b11, "R3 sreg full");
    chk("R2 layout", csr_rdata, 32'h007F_001F);
    do_write(1'b1, 2'b11, 32'h0015_000A);
    do_read(1'b1, 2'b11, "R3 mreg");

    // R7: window 3 unlocked, 23 kept, 24 dropped
    set_cfg(1'b0, 4'd3, 4'd3);
    do_write(1'b0, 2'b11, 32'h0);
    do_write(1'b0, 2'b01, 32'h0000_0017);
    do_read(1'b0, 2'b11, "R7 accept 23");
    chk("R7 rcid 23", DW'(csr_rdata[RW-1:0]), 32'd23);
    do_write(1'b0, 2'b01, 32'h0000_0018);
    do_read(1'b0, 2'b11, "R7 drop 24");
    chk("R7 rcid still 23", DW'(csr_rdata[RW-1:0]), 32'd23);

    // R6 / R5: locked prefix of 24
    set_cfg(1'b1, 4'd3, 4'd2);
    do_write(1'b0, 2'b11, 32'h0040_0018);
    do_write(1'b0, 2'b01, 32'h0003_0005);
    do_read(1'b0, 2'b11, "R6 merged");
    chk("R6 rcid 29", DW'(csr_rdata[RW-1:0]), 32'd29);
    do_read(1'b0, 2'b01, "R5 hidden read");
    chk("R5 rcid low", DW'(csr_rdata[RW-1:0]), 32'd5);
    set_cfg(1'b0, 4'd3, 4'd2);
    do_read(1'b0, 2'b01, "R5 unlocked read");

    // R8: window 15 acts as 12
    set_cfg(1'b1, 4'd15, 4'd13);
    do_write(1'b0, 2'b00, 32'h0011_0002);
    do_read(1'b0, 2'b11, "R8 clamp locked");
    set_cfg(1'b0, 4'd15, 4'd14);
    do_write(1'b0, 2'b00, 32'h0001_0001);
    do_read(1'b0, 2'b11, "R8 clamp unlocked");

    // R4: machine register below machine level
    do_write(1'b1, 2'b01, 32'h0000_0003);
    do_read(1'b1, 2'b11, "R4 mreg unchanged");
    do_read(1'b1, 2'b01, "R4 mreg hidden");

    // R10: select with no strobe
    do_read(1'b0, 2'b11, "R10 idle");
    check_req(2'b01);
    check_req(2'b11);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] pr;
      pr = ($urandom % 3 == 0) ? 2'b11 : 2'($urandom % 2);
      set_cfg(1'($urandom), 4'($urandom), 4'($urandom));
      sup_qrid = 4'($urandom); mach_qrid = 4'($urandom);
      if ($urandom % 4 != 0) do_write(1'($urandom), pr, $urandom);
      do_read(1'b1, 2'b11, "R3 rand mreg");
      do_read(1'b0, 2'b11, "R6 R7 rand sreg");
      do_read(1'b0, pr, "R5 rand read");
      check_req(2'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule